// File: doc/BRIEF.md
# ADPCM Command Stream Interpreter

This block sits between a byte source (a ROM fetcher or a host port) and an ADPCM nibble decoder. It reads each incoming byte either as a command or as packed sample data. Commands can insert a timed silence, select the decoder sample rate, start a burst of a fixed or counted number of 4-bit codes, or end the current sample. Data bytes are split into two 4-bit codes, high half first. The codes go out one per sample-rate tick.

The byte source is paced by a data-request output, and a byte is taken only in a cycle where that request is high. In host mode the first write to an idle engine only wakes it up. In ROM mode a start pulse wakes it up. A `playing` flag is high while the engine is active. A one-cycle pulse marks the end of a sample.

The sample-rate tick is derived from a base tick, which is the clock divided by `PRE_DIV` (nominally 160 kHz). That base tick is then divided by the 5-bit rate field plus one. Silence is measured in units of `SIL_TICKS` base ticks (nominally 1 ms).

Top module: `adpcm_cmd_stream`

## Requirements
- R1: An idle engine is woken either by a start pulse (when `host_mode`=0) or by any `in_valid` write (when `host_mode`=1). That waking write is not interpreted. After waking, `playing` and `data_req` are high. A byte offered while `data_req` is low is ignored.
- R2: A data byte yields two codes, bits [7:4] first and then bits [3:0]. Each code is output with a one-cycle `nib_valid`, and `nib_valid` is only ever high together with `rate_tick`.
- R3: A command with bits [7:6]=01 loads bits [4:0] as the rate field and plays the next 256 codes (128 data bytes).
- R4: A command with bits [7:6]=10 loads the rate field from bits [4:0]. The following byte n is a count, and the next n+1 codes are played. When n+1 is odd, the low half of the last data byte is dropped, and the byte after it is read as a command.
- R5: While `playing` is high, `rate_tick` pulses once every (rate+1)*`PRE_DIV` clock cycles.
- R6: A byte with bits [7:6]=00 and a nonzero value d inserts a silence of d*`SIL_TICKS` base ticks. During the silence `data_req` is low and no code is output.
- R7: Byte 0x00 received as a command after playback has begun drops `playing` and pulses `sample_end` for one cycle.
- R8: Byte 0xFF received as a command after playback has begun also ends the sample, in the same way as R7.
- R9: Playback counts as begun once a command other than 0x00 or 0xFF has been received. A 0x00 or 0xFF seen before that point is ignored, and the engine keeps requesting commands.
- R10: A command with bits [7:6]=11 other than 0xFF produces no codes and sets `cmd_unknown`. That flag stays set until the engine is next woken.
- R11: While `rst_n` is low, every output is held low on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_mode | input | 1 | 1: host feeds bytes directly; 0: ROM fetcher feeds bytes |
| start_pulse | input | 1 | Wakes the engine when it is idle and `host_mode`=0 |
| in_valid | input | 1 | Byte offered on `in_data` |
| in_data | input | 8 | Command or data byte |
| data_req | output | 1 | Engine takes the byte offered in this cycle |
| playing | output | 1 | Engine active |
| nib_valid | output | 1 | `nib_data` holds a new code |
| nib_data | output | 4 | ADPCM code to the decoder |
| rate_tick | output | 1 | Decoder sample-rate tick |
| sample_end | output | 1 | One-cycle pulse when a sample ends |
| cmd_unknown | output | 1 | Sticky flag: an unknown 11xxxxxx command was seen |

## Verification
The bench builds the block with `PRE_DIV`=2 and `SIL_TICKS`=3. With these values a silence unit is six clocks, and a full 256-code burst at the fastest rate takes about 512 clocks. Random multi-segment streams therefore fit comfortably in a run, while still covering the fixed and counted bursts, the odd-count drop, silences, unknown commands and both end markers. The rate-tick period is measured at rate field 5, where the expected spacing is twelve clocks.

// File: rtl/adpcm_cmd_pkg.sv
// Shared types and constants for the ADPCM command stream interpreter.
// Assumes the byte format: two top bits select the command class, the
// low five bits carry the rate field of a burst command.
package adpcm_cmd_pkg;
    localparam int RATE_W    = 5;
    localparam int SIL_W     = 6;
    localparam int CNT_W     = 9;
    localparam int FIXED_LEN = 256;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_CNT,
        S_DATA,
        S_SIL
    } parse_state_t;

    // Bytes that do not mark playback as begun.
    function automatic logic is_marker(input logic [7:0] b);
        return (b == 8'h00) || (b == 8'hFF);
    endfunction
endpackage

// File: rtl/adpcm_rate_timer.sv
// Timing source: base tick prescaler, sample-rate divider and silence
// counter. Assumes PRE_DIV >= 1 and SIL_TICKS >= 1. Counters are held
// at zero while run is low, so tick phase restarts on every wake-up.
module adpcm_rate_timer #(
    parameter int PRE_DIV   = 4,
    parameter int SIL_TICKS = 160,
    parameter int RATE_W    = 5,
    parameter int SIL_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    input  logic              sil_start,
    input  logic [SIL_W-1:0]  sil_units,
    output logic              tick,
    output logic              rate_tick,
    output logic              sil_busy
);
    localparam int PRE_CW = $clog2(PRE_DIV) + 1;
    localparam int SUB_W  = $clog2(SIL_TICKS) + 1;

    logic [PRE_CW-1:0] pre_cnt;
    logic [RATE_W-1:0] rate_cnt;
    logic [SIL_W-1:0]  sil_left;
    logic [SUB_W-1:0]  sub_cnt;
    logic              base;

    assign base     = run && (pre_cnt == PRE_CW'(PRE_DIV - 1));
    assign tick     = base && (rate_cnt >= rate);
    assign sil_busy = (sil_left != '0);

    // Prescaler producing the base tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  pre_cnt <= '0;
        else if (base)       pre_cnt <= '0;
        else                 pre_cnt <= pre_cnt + 1'b1;
    end

    // Rate divider counting base ticks up to the rate field.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)              rate_cnt <= '0;
        else if (base && rate_cnt >= rate) rate_cnt <= '0;
        else if (base)                   rate_cnt <= rate_cnt + 1'b1;
    end

    // Registered copy of the sample-rate tick for the decoder.
    always_ff @(posedge clk) begin
        if (!rst_n) rate_tick <= 1'b0;
        else        rate_tick <= tick;
    end

    // Silence counter: units of SIL_TICKS base ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sil_left <= '0;
            sub_cnt  <= '0;
        end else if (sil_start) begin
            sil_left <= sil_units;
            sub_cnt  <= '0;
        end else if (sil_busy && base) begin
            if (sub_cnt == SUB_W'(SIL_TICKS - 1)) begin
                sub_cnt  <= '0;
                sil_left <= sil_left - 1'b1;
            end else begin
                sub_cnt <= sub_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/adpcm_nibble_feed.sv
// One-byte holding buffer that splits data bytes into two codes, high
// half first, one per tick, and counts down the burst length. Assumes a
// byte is loaded only while empty and a count only with no byte held.
module adpcm_nibble_feed #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic             load_cnt,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             load_byte,
    input  logic [7:0]       byte_in,
    output logic             busy,
    output logic             rem_zero,
    output logic             nib_valid,
    output logic [3:0]       nib_data
);
    logic [CNT_W-1:0] left;
    logic [7:0]       hold;
    logic             lo_next;

    assign rem_zero = (left == '0);

    // Holds the byte, emits codes on ticks and counts the burst down.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            left      <= '0;
            hold      <= '0;
            busy      <= 1'b0;
            lo_next   <= 1'b0;
            nib_valid <= 1'b0;
            nib_data  <= '0;
        end else begin
            nib_valid <= 1'b0;
            if (load_cnt) begin
                left <= cnt_val;
            end
            if (load_byte) begin
                hold    <= byte_in;
                busy    <= 1'b1;
                lo_next <= 1'b0;
            end else if (busy && tick) begin
                nib_data  <= lo_next ? hold[3:0] : hold[7:4];
                nib_valid <= 1'b1;
                left      <= left - 1'b1;
                if (lo_next || left == CNT_W'(1)) begin
                    busy    <= 1'b0;
                    lo_next <= 1'b0;
                end else begin
                    lo_next <= 1'b1;
                end
            end
        end
    end

    // R4
    full_has_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rem_zero);
endmodule

// File: rtl/adpcm_cmd_fsm.sv
// Command parser: decodes each accepted byte by class, drives the timer
// and the code buffer, and tracks the begun and unknown-command flags.
// Assumes the code buffer is empty before any command is taken.
module adpcm_cmd_fsm
    import adpcm_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_mode,
    input  logic              start_pulse,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              busy,
    input  logic              rem_zero,
    input  logic              sil_busy,
    output logic              data_req,
    output logic              run,
    output logic              clear,
    output logic [RATE_W-1:0] rate,
    output logic              sil_start,
    output logic [SIL_W-1:0]  sil_units,
    output logic              load_cnt,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              load_byte,
    output logic              eos,
    output logic              unk
);
    parse_state_t state;
    logic         begun;
    logic         accept;
    logic         cmd_take;

    assign data_req  = (state == S_CMD) || (state == S_CNT) ||
                       (state == S_DATA && !busy && !rem_zero);
    assign accept    = in_valid && data_req;
    assign cmd_take  = accept && (state == S_CMD);
    assign clear     = (state == S_IDLE) && (host_mode ? in_valid : start_pulse);
    assign run       = (state != S_IDLE);
    assign sil_units = in_data[SIL_W-1:0];
    assign sil_start = cmd_take && (in_data[7:6] == 2'b00) && (in_data != 8'h00);
    assign load_cnt  = (cmd_take && in_data[7:6] == 2'b01) ||
                       (accept && state == S_CNT);
    assign cnt_val   = (state == S_CNT) ? ({1'b0, in_data} + CNT_W'(1))
                                        : CNT_W'(FIXED_LEN);
    assign load_byte = accept && (state == S_DATA);

    // Parser state, flags and rate field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            begun <= 1'b0;
            unk   <= 1'b0;
            rate  <= '0;
            eos   <= 1'b0;
        end else begin
            eos <= 1'b0;
            case (state)
                S_IDLE: if (clear) begin
                    state <= S_CMD;
                    begun <= 1'b0;
                    unk   <= 1'b0;
                end
                S_CMD: if (accept) begin
                    if (is_marker(in_data)) begin
                        if (begun) begin
                            state <= S_IDLE;
                            eos   <= 1'b1;
                        end
                    end else begin
                        begun <= 1'b1;
                        case (in_data[7:6])
                            2'b00: state <= S_SIL;
                            2'b01: begin
                                rate  <= in_data[RATE_W-1:0];
                                state <= S_DATA;
                            end
                            2'b10: begin
                                rate  <= in_data[RATE_W-1:0];
                                state <= S_CNT;
                            end
                            default: unk <= 1'b1;
                        endcase
                    end
                end
                S_CNT:  if (accept) state <= S_DATA;
                S_DATA: if (rem_zero && !busy) state <= S_CMD;
                S_SIL:  if (!sil_busy) state <= S_CMD;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R6
    quiet_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SIL) |-> !busy);
    // R7
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos |-> (state == S_IDLE));
    // R9
    begun_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_take && !begun && is_marker(in_data)) |=> (state == S_CMD));
endmodule

// File: rtl/adpcm_cmd_stream.sv
// Top of the ADPCM command stream interpreter: wires the parser, the
// timing source and the code buffer. Assumes the byte source honours
// data_req and the decoder takes every code on its nib_valid cycle.
module adpcm_cmd_stream
    import adpcm_cmd_pkg::*;
#(
    parameter int PRE_DIV   = 4,
    parameter int SIL_TICKS = 160
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_mode,
    input  logic       start_pulse,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       data_req,
    output logic       playing,
    output logic       nib_valid,
    output logic [3:0] nib_data,
    output logic       rate_tick,
    output logic       sample_end,
    output logic       cmd_unknown
);
    logic              busy, rem_zero, sil_busy, tick, clear;
    logic              sil_start, load_cnt, load_byte;
    logic [RATE_W-1:0] rate;
    logic [SIL_W-1:0]  sil_units;
    logic [CNT_W-1:0]  cnt_val;

    adpcm_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
        .start_pulse(start_pulse), .in_valid(in_valid), .in_data(in_data),
        .busy(busy), .rem_zero(rem_zero), .sil_busy(sil_busy),
        .data_req(data_req), .run(playing), .clear(clear), .rate(rate),
        .sil_start(sil_start), .sil_units(sil_units), .load_cnt(load_cnt),
        .cnt_val(cnt_val), .load_byte(load_byte), .eos(sample_end),
        .unk(cmd_unknown)
    );

    adpcm_rate_timer #(
        .PRE_DIV(PRE_DIV), .SIL_TICKS(SIL_TICKS),
        .RATE_W(RATE_W), .SIL_W(SIL_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .run(playing), .rate(rate),
        .sil_start(sil_start), .sil_units(sil_units), .tick(tick),
        .rate_tick(rate_tick), .sil_busy(sil_busy)
    );

    adpcm_nibble_feed #(.CNT_W(CNT_W)) u_feed (
        .clk(clk), .rst_n(rst_n), .clear(clear), .tick(tick),
        .load_cnt(load_cnt), .cnt_val(cnt_val), .load_byte(load_byte),
        .byte_in(in_data), .busy(busy), .rem_zero(rem_zero),
        .nib_valid(nib_valid), .nib_data(nib_data)
    );

    // R1
    req_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_req |-> playing);
    // R2
    nib_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nib_valid |-> rate_tick);
endmodule

// File: tb/adpcm_cmd_stream_tb.sv
`timescale 1ns/1ps
module adpcm_cmd_stream_tb;
    localparam int PRE = 2;
    localparam int SIL = 3;

    logic clk = 1'b0, rst_n = 1'b0, host_mode = 1'b0, start_pulse = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic data_req, playing, nib_valid, rate_tick, sample_end, cmd_unknown;
    logic [3:0] nib_data;

    adpcm_cmd_stream #(.PRE_DIV(PRE), .SIL_TICKS(SIL)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
        .start_pulse(start_pulse), .in_valid(in_valid), .in_data(in_data),
        .data_req(data_req), .playing(playing), .nib_valid(nib_valid),
        .nib_data(nib_data), .rate_tick(rate_tick), .sample_end(sample_end),
        .cmd_unknown(cmd_unknown)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int gl = 0, eos_n = 0, last_t = -1, last_iv = 0;
    logic [7:0] prog [0:1023];
    logic [3:0] expn [0:4095];
    logic [3:0] got  [0:4095];
    bit sil_mark [0:1023];
    bit pre_mark [0:1023];
    int plen = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Output monitors sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && nib_valid && gl < 4096) begin
            got[gl] = nib_data;
            gl++;
        end
        if (rst_n && sample_end) eos_n++;
        if (rst_n && rate_tick) begin
            if (last_t >= 0) last_iv = cyc - last_t;
            last_t = cyc;
        end
    end

    task automatic push(input logic [7:0] v);
        prog[plen] = v;
        plen++;
    endtask

    // Expected code stream, unknown flag and consumed length from the rules.
    task automatic model(output int elen, output bit eunk, output int used);
        int i;
        bit begun;
        int n;
        logic [7:0] b;
        i = 0; begun = 0; elen = 0; eunk = 0; used = plen;
        for (int k = 0; k < 1024; k++) begin
            sil_mark[k] = 0;
            pre_mark[k] = 0;
        end
        while (i < plen) begin
            b = prog[i];
            i++;
            if (b == 8'h00 || b == 8'hFF) begin
                if (begun) begin
                    used = i;
                    break;
                end
                pre_mark[i-1] = 1;
            end else begin
                begun = 1;
                n = 0;
                case (b[7:6])
                    2'b00: sil_mark[i-1] = 1;
                    2'b01: n = 256;
                    2'b10: begin
                        n = int'(prog[i]) + 1;
                        i++;
                    end
                    default: eunk = 1;
                endcase
                for (int k = 0; k < n; k++) begin
                    expn[elen] = (k % 2 == 0) ? prog[i + k/2][7:4] : prog[i + k/2][3:0];
                    elen++;
                end
                i += (n + 1) / 2;
            end
        end
    endtask

    // Offer one byte once data_req is high; optionally offer junk while low.
    task automatic feed_byte(input logic [7:0] b, input bit junk, output bit to);
        int w;
        w = 0;
        to = 0;
        forever begin
            @(negedge clk);
            if (data_req) break;
            in_valid = junk;
            in_data  = 8'h41;
            w++;
            if (w > 20000) begin
                in_valid = 1'b0;
                to = 1;
                check(0, "R1 data_req timeout", 0, 1);
                return;
            end
        end
        in_valid = 1'b1;
        in_data  = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic run_prog(input bit hm, input int exp_iv);
        int elen, used, mism, k, g0, lo, hi;
        bit eunk, to;
        model(elen, eunk, used);
        gl = 0; eos_n = 0; last_t = -1; last_iv = 0;
        @(negedge clk);
        host_mode = hm;
        if (hm) begin
            in_valid = 1'b1;
            in_data  = 8'h41;
        end else begin
            start_pulse = 1'b1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        start_pulse = 1'b0;
        @(negedge clk);
        check(playing && data_req, "R1 wake-up", {playing, data_req}, 3);
        for (int i = 0; i < used; i++) begin
            feed_byte(prog[i], hm, to);
            if (to) return;
            if (sil_mark[i]) begin
                g0 = gl;
                k = 0;
                do begin
                    @(negedge clk);
                    k++;
                end while (!data_req && k < 10000);
                lo = (int'(prog[i][5:0]) * SIL - 1) * PRE + 1;
                hi = int'(prog[i][5:0]) * SIL * PRE + 2;
                check(k >= lo && k <= hi, "R6 silence length", k, hi);
                check(gl == g0, "R6 no codes in silence", gl, g0);
            end
            if (pre_mark[i]) begin
                @(negedge clk);
                check(playing && data_req, "R9 marker before begun ignored",
                      {playing, data_req}, 3);
            end
        end
        k = 0;
        while (playing && k < 20000) begin
            @(negedge clk);
            k++;
        end
        repeat (3) @(negedge clk);
        if (prog[used-1] == 8'hFF)
            check(!playing, "R8 0xFF ends sample", playing, 0);
        else
            check(!playing, "R7 0x00 ends sample", playing, 0);
        check(eos_n == 1, "R7 sample_end pulses", eos_n, 1);
        check(gl == elen, "R2 R3 R4 code count", gl, elen);
        mism = 0;
        for (int j = 0; j < elen && j < gl; j++) begin
            if (got[j] !== expn[j]) begin
                if (mism == 0)
                    $display("FAIL R2 R4 code %0d actual=%0d expected=%0d", j, got[j], expn[j]);
                mism++;
            end
        end
        check(mism == 0, "R2 R3 R4 code values", mism, 0);
        check(cmd_unknown == eunk, "R10 unknown flag", cmd_unknown, eunk);
        check(!data_req, "R1 no request when idle", data_req, 0);
        if (exp_iv > 0) check(last_iv == exp_iv, "R5 rate tick spacing", last_iv, exp_iv);
    endtask

    task automatic gen();
        int nseg, kind, n;
        plen = 0;
        if ($urandom % 2) push(8'hFF);
        if ($urandom % 2) push(8'h00);
        nseg = 2 + $urandom % 5;
        for (int s = 0; s < nseg; s++) begin
            kind = (s == 0) ? 0 : int'($urandom % 8);
            if (kind == 4 && ($urandom % 3 == 0)) begin
                push(8'h40 | 8'($urandom % 2));
                for (int j = 0; j < 128; j++) push(8'($urandom));
            end else if (kind == 4 || kind == 5) begin
                push(8'($urandom % 3 + 1));
            end else if (kind == 6) begin
                push(8'hC0 | 8'($urandom % 63));
            end else begin
                n = $urandom % 24;
                push(8'h80 | 8'($urandom % 4) | 8'(($urandom % 2) << 5));
                push(8'(n));
                for (int j = 0; j < (n + 2) / 2; j++) push(8'($urandom));
            end
        end
        push(8'h00);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!playing && !data_req && !nib_valid && !rate_tick && !sample_end && !cmd_unknown,
              "R11 reset outputs", {playing, data_req, nib_valid, cmd_unknown}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed host-mode stream: markers, odd count, unknown, silence, rate 5.
        plen = 0;
        push(8'hFF); push(8'h00);
        push(8'h82); push(8'h06); push(8'h12); push(8'h34); push(8'h56); push(8'h78);
        push(8'hC3);
        push(8'h02);
        push(8'hA5); push(8'h07); push(8'h9A); push(8'hBC); push(8'hDE); push(8'hF1);
        push(8'h00);
        run_prog(1'b1, 6 * PRE);

        // ROM-mode: 0xFF end after begun (R8), cmd_unknown cleared on wake (R10).
        plen = 0;
        push(8'h80); push(8'h01); push(8'hAB); push(8'hFF);
        run_prog(1'b0, 0);

        // R3 fixed 256-code burst at rate 0.
        plen = 0;
        push(8'h40);
        for (int j = 0; j < 128; j++) push(8'(j * 37 + 5));
        push(8'h00);
        run_prog(1'b0, 0);

        // Constrained random streams in both modes.
        for (int r = 0; r < 6; r++) begin
            gen();
            run_prog(r[0], 0);
        end

        // R11 reset while playing.
        @(negedge clk);
        host_mode = 1'b0;
        start_pulse = 1'b1;
        @(negedge clk);
        start_pulse = 1'b0;
        in_valid = 1'b1;
        in_data = 8'h40;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(!playing && !data_req && !nib_valid, "R11 reset mid-play",
              {playing, data_req, nib_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule